// File: doc/BRIEF.md
# Key-Protected Interrupt Level Gate

This block holds a 4-bit interrupt mask level in a 32-bit register and uses it to filter a set of interrupt request sources. The register is changed only by a write whose top byte carries a fixed unlock key. Any other write leaves the level as it was, so a stray store cannot lower or raise the threshold by accident.

Each source presents a request bit and a 4-bit priority level. A request survives only when its level is strictly above the stored mask. Level 0 marks a disabled source and never survives. Among the surviving requests, the block reports the one with the highest level to the CPU side, together with its index and its level. When levels tie, the lowest source index wins.

The report is a plain combinational status output with no back-pressure. It follows the request inputs in the same cycle and carries no handshake. The register port is a single-cycle select/write-enable interface, and its read data is formatted combinationally.

Top module: `irq_level_gate`

## Requirements
- R1: After reset the mask level is 0, so a selected read returns 0x00000000.
- R2: A write with `reg_sel` and `reg_we` high and `reg_wdata[31:24]` equal to 0xA5 stores `reg_wdata[7:4]` as the mask at that clock edge.
- R3: A write whose `reg_wdata[31:24]` is not 0xA5 leaves the mask unchanged.
- R4: While `reg_sel` is high, `reg_rdata[7:4]` shows the mask and every other bit reads 0, including bits 31:24 whatever key was written; while `reg_sel` is low, `reg_rdata` is 0.
- R5: Source i passes only when `src_req[i]` is high and its level `src_lvl[4*i+3:4*i]` is strictly greater than the mask. A level equal to the mask is blocked. `irq_valid` is high exactly when at least one source passes.
- R6: A source whose level is 0 never passes. With the mask at 0, every requesting source with a nonzero level passes.
- R7: When `irq_valid` is high, `irq_level` is the largest level among the passing sources, and `irq_index` names a passing source with that level.
- R8: When several passing sources share the largest level, `irq_index` is the lowest of their indices.
- R9: A keyed write takes effect at the clock edge that samples it. The filter uses the new mask from the following cycle onward, and the old mask until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable (qualified by reg_sel) |
| reg_wdata | input | 32 | Write data; key in bits 31:24, level in bits 7:4 |
| reg_rdata | output | 32 | Formatted read data |
| src_req | input | NUM_SRC | Request bit per source |
| src_lvl | input | 4*NUM_SRC | Priority level per source, source i in bits 4i+3:4i |
| irq_valid | output | 1 | A request survives the mask |
| irq_index | output | max(1,clog2(NUM_SRC)) | Index of the reported source |
| irq_level | output | 4 | Level of the reported source |

## Verification
The assertions assume that `reg_sel`, `reg_we` and `reg_wdata` are settled before each rising edge. They also assume that the request inputs hold steady through the sampling edge. The bench changes every input only at the falling edge and compares the outputs shortly after that, well before the next rising edge. Random writes pick the correct key about half the time, and random request levels cover 0 through 15. Directed cases pin down equality with the mask, level 0 with mask 0, ties, and a mask of 15.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int         LVL_W    = 4;
  localparam int         DATA_W   = 32;
  localparam int         KEY_W    = 8;
  localparam int         KEY_LSB  = DATA_W - KEY_W;
  localparam int         FIELD_LO = 4;
  localparam int         FIELD_HI = FIELD_LO + LVL_W - 1;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 8'hA5;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/gate_mask_reg.sv
module gate_mask_reg
  import irq_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output lvl_t              mask,
  output logic [DATA_W-1:0] rdata
);
  logic key_ok;
  logic commit;

  assign key_ok = (wdata[DATA_W-1:KEY_LSB] == UNLOCK_KEY);
  assign commit = sel && we && key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (commit) mask <= wdata[FIELD_HI:FIELD_LO];
  end

  always_comb begin
    rdata = '0;
    if (sel) rdata[FIELD_HI:FIELD_LO] = mask;
  end

  p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> (mask == '0));
  p_key_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && wdata[DATA_W-1:KEY_LSB] == 8'hA5) |=> (mask == $past(wdata[FIELD_HI:FIELD_LO])));
  p_bad_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[DATA_W-1:KEY_LSB] != 8'hA5) |=> $stable(mask));
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[DATA_W-1:FIELD_HI+1] == '0) && (rdata[FIELD_LO-1:0] == '0));
endmodule

// File: rtl/gate_level_filter.sv
module gate_level_filter
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  input  lvl_t                     mask,
  output logic [NUM_SRC-1:0]       pass
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lvl_t my_lvl;
    assign my_lvl  = lvl[g*LVL_W +: LVL_W];
    assign pass[g] = req[g] && (my_lvl > mask);

    p_zero_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (my_lvl == '0) |-> !pass[g]);
  end
endmodule

// File: rtl/gate_max_select.sv
module gate_max_select
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pass,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  output logic                     valid,
  output logic [IDX_W-1:0]         index,
  output lvl_t                     level
);
  always_comb begin
    valid = 1'b0;
    index = '0;
    level = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pass[i] && (lvl[i*LVL_W +: LVL_W] > level)) begin
        valid = 1'b1;
        index = IDX_W'(i);
        level = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    p_is_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pass[g] |-> (valid && lvl[g*LVL_W +: LVL_W] <= level));
    p_tie_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pass[g] && lvl[g*LVL_W +: LVL_W] == level) |-> (int'(index) <= g));
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_sel,
  input  logic                         reg_we,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [NUM_SRC-1:0]           src_req,
  input  logic [NUM_SRC*4-1:0]         src_lvl,
  output logic                         irq_valid,
  output logic [IDX_W-1:0]             irq_index,
  output logic [3:0]                   irq_level
);
  lvl_t               mask;
  logic [NUM_SRC-1:0] pass;

  gate_mask_reg u_reg (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
    .wdata(reg_wdata), .mask(mask), .rdata(reg_rdata)
  );

  gate_level_filter #(.NUM_SRC(NUM_SRC)) u_filt (
    .clk(clk), .rst_n(rst_n), .req(src_req), .lvl(src_lvl),
    .mask(mask), .pass(pass)
  );

  gate_max_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk(clk), .rst_n(rst_n), .pass(pass), .lvl(src_lvl),
    .valid(irq_valid), .index(irq_index), .level(irq_level)
  );

  p_above_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > mask));
  p_src_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (src_req[irq_index] && src_lvl[irq_index*4 +: 4] == irq_level));
  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != 4'd0));
endmodule

// File: tb/sim_irq_level_gate.sv
`timescale 1ns/1ps
module sim_irq_level_gate;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_sel = 1'b0, reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  src_req = '0;
  logic [N*4-1:0] src_lvl = '0;
  logic          irq_valid;
  logic [IW-1:0] irq_index;
  logic [3:0]    irq_level;

  int errors = 0, checks = 0;
  logic [3:0] m_mask = 4'd0;

  always #2.5 clk = ~clk;

  irq_level_gate #(.NUM_SRC(N)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_out(input logic [N-1:0] rq, input logic [N*4-1:0] lv, input logic [3:0] m);
    logic v = 1'b0; logic [IW-1:0] ix = '0; logic [3:0] bl = '0;
    for (int i = 0; i < N; i++)
      if (rq[i] && lv[i*4 +: 4] > m && lv[i*4 +: 4] > bl) begin
        v = 1'b1; ix = IW'(i); bl = lv[i*4 +: 4];
      end
    return {1'b0, v, ix, bl};
  endfunction

  task automatic check_irq(input string req);
    logic [8:0] e = expect_out(src_req, src_lvl, m_mask);
    check({irq_valid, irq_index, irq_level} == e[7:0], req, 32'({irq_valid, irq_index, irq_level}), 32'(e[7:0]));
  endtask

  // drive at negedge, check before the next rising edge, then update the model
  task automatic cycle(input logic sel, input logic we, input logic [31:0] wd,
                       input logic [N-1:0] rq, input logic [N*4-1:0] lv, input string req);
    @(negedge clk);
    reg_sel = sel; reg_we = we; reg_wdata = wd; src_req = rq; src_lvl = lv;
    #1;
    check_irq(req);
    if (sel) check(reg_rdata == {24'd0, m_mask, 4'd0}, "R4 read", reg_rdata, {24'd0, m_mask, 4'd0});
    else     check(reg_rdata == 32'd0, "R4 unselected", reg_rdata, 32'd0);
    @(posedge clk);
    if (sel && we && wd[31:24] == 8'hA5) m_mask = wd[7:4];
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    cycle(1'b1, 1'b0, 32'd0, '1, {N{4'h5}}, "R1 reset mask 0");
    // R6: mask 0, level 0 blocked, others pass
    cycle(1'b0, 1'b0, 32'd0, 8'hFF, 32'h1000_0000, "R6 zero level");
    // R2 keyed write to 7, other bits junk; R4 readback shows only 7:4
    cycle(1'b1, 1'b1, 32'hA5FF_FF7F, '0, '0, "R2 write");
    cycle(1'b1, 1'b0, 32'd0, 8'h03, 32'h0000_0087, "R9 new mask applies");
    check(reg_rdata == 32'h70, "R2 mask stored", reg_rdata, 32'h70);
    // R5 equal level blocked, one above passes
    cycle(1'b0, 1'b0, 32'd0, 8'h03, 32'h0000_0077, "R5 equal blocked");
    cycle(1'b0, 1'b0, 32'd0, 8'h0F, 32'h0000_8877, "R8 tie lowest");
    // R3 bad key
    cycle(1'b1, 1'b1, 32'hA4FF_FF2F, '0, '0, "R3 bad key write");
    cycle(1'b1, 1'b0, 32'd0, 8'hFF, 32'h1234_5678, "R3 mask unchanged");
    check(reg_rdata == 32'h70, "R3 mask held", reg_rdata, 32'h70);
    // R9: same cycle as write still uses old mask
    cycle(1'b1, 1'b1, 32'hA500_00F0, 8'hFF, 32'hFFFF_FFFF, "R9 old mask in write cycle");
    cycle(1'b0, 1'b0, 32'd0, 8'hFF, 32'hFFFF_FFFF, "R5 mask 15 blocks all");
    check(irq_valid == 1'b0, "R5 none pass", 32'(irq_valid), 32'd0);
    cycle(1'b1, 1'b1, 32'hA500_0000, '0, '0, "R2 clear");
    // R7 random
    for (int k = 0; k < 400; k++) begin
      logic [31:0] wd = $urandom;
      logic do_wr = ($urandom % 4 == 0);
      if ($urandom % 2 == 0) wd[31:24] = 8'hA5;
      cycle($urandom % 2 == 0, do_wr, wd, N'($urandom), {$urandom}, "R7 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule